// File: doc/BRIEF.md
# Single-to-Dual Pixel Packer

This block takes a video stream at one pixel per clock and combines each pair of consecutive pixels into one word for a dual-pixel output interface. The output pair rate is half the input pixel rate. Each input pixel carries RGB colour, horizontal sync, vertical sync, data enable and one general-purpose spare bit. Each output word holds the RGB of the odd pixel, the RGB of the even pixel, one shared set of the three control signals, and the spare bit of each pixel. A one-cycle valid strobe marks each new word.

Pairing follows the start of active video. Every rising edge of data enable forces the pixel that arrives with it into the odd slot. The first active pixel of each line is therefore always the odd half of a pair, whatever phase the packer was in before. During blanking the packer keeps forming pairs at the same cadence. When a line ends on an unpaired pixel, the packer closes that pair with an even half of zero colour.

Top module: `pix_pair_packer`

## Requirements
- R1: After reset is released, and before any pixel is accepted, `valid_o` is low and all output data fields read zero.
- R2: The pixel sampled in the same cycle that `de_i` rises from 0 to 1 takes the odd slot. In the cycle after that pixel is sampled, `valid_o` is low.
- R3: When the even-slot pixel is sampled, `valid_o` is high for the next cycle. In that cycle `odd_rgb_o` holds the first pixel of the pair and `even_rgb_o` holds the second.
- R4: `valid_o` is never high in two consecutive cycles. While `de_i` stays low, pairs keep being emitted, one every second cycle.
- R5: In each emitted word, `hs_o` and `vs_o` take the values of the second pixel of the pair, and `de_o` takes the data enable of the first pixel.
- R6: `odd_gp_o` and `even_gp_o` carry the spare bits of the first and second pixel unchanged, including in a padded pair.
- R7: If the first pixel of a pair was active (`de_i`=1) and the second was not, the pair is emitted with `even_rgb_o` equal to zero and `de_o` equal to 1.
- R8: When `de_i` rises while an unpaired odd pixel from blanking is pending, that pending pixel is dropped and never appears on the output.
- R9: Between valid strobes, all output data fields keep the values of the last emitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, input rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rgb_i | input | 24 | Input pixel colour (NUM_CH*CH_W) |
| hs_i | input | 1 | Input horizontal sync |
| vs_i | input | 1 | Input vertical sync |
| de_i | input | 1 | Input data enable |
| gp_i | input | 1 | Input spare bit |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| odd_rgb_o | output | 24 | Colour of the first (odd) pixel |
| even_rgb_o | output | 24 | Colour of the second (even) pixel, zero when padded |
| hs_o | output | 1 | Horizontal sync, shared by both halves |
| vs_o | output | 1 | Vertical sync, shared by both halves |
| de_o | output | 1 | Data enable, shared by both halves |
| odd_gp_o | output | 1 | Spare bit of the odd pixel |
| even_gp_o | output | 1 | Spare bit of the even pixel |

## Verification
The bench uses the default parameters: three channels of eight bits each, giving 24-bit colour. It drives distinct byte patterns in every channel, so the tests would reveal a swapped or truncated channel in either half of the pair. Because the parameters are small, a short directed run covers every phase transition. The runs include an even-length line, a blanking stretch, an odd-length line that needs padding, and a data enable rise that cuts off a pending blanking pixel.

// File: rtl/pix_pair_pkg.sv
package pix_pair_pkg;
  typedef enum logic {
    SLOT_ODD  = 1'b0,
    SLOT_EVEN = 1'b1
  } slot_e;
endpackage

// File: rtl/pp_phase_trk.sv
module pp_phase_trk
  import pix_pair_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  de_i,
  output slot_e slot_o
);
  logic  de_q;
  slot_e phase_q;
  logic  start;

  assign start  = de_i & ~de_q;
  // a rising DE forces the odd slot regardless of the running phase
  assign slot_o = start ? SLOT_ODD : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q    <= 1'b0;
      phase_q <= SLOT_ODD;
    end else begin
      de_q    <= de_i;
      phase_q <= (slot_o == SLOT_ODD) ? SLOT_EVEN : SLOT_ODD;
    end
  end
endmodule

// File: rtl/pp_odd_hold.sv
module pp_odd_hold #(
  parameter int RGB_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [RGB_W-1:0] rgb_i,
  input  logic             de_i,
  input  logic             gp_i,
  output logic [RGB_W-1:0] odd_rgb_o,
  output logic             odd_de_o,
  output logic             odd_gp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_rgb_o <= '0;
      odd_de_o  <= 1'b0;
      odd_gp_o  <= 1'b0;
    end else if (cap_i) begin
      odd_rgb_o <= rgb_i;
      odd_de_o  <= de_i;
      odd_gp_o  <= gp_i;
    end
  end
endmodule

// File: rtl/pp_pair_out.sv
module pp_pair_out #(
  parameter int CH_W   = 8,
  parameter int NUM_CH = 3,
  localparam int RGB_W = CH_W * NUM_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic [RGB_W-1:0] odd_rgb_i,
  input  logic             odd_de_i,
  input  logic             odd_gp_i,
  input  logic [RGB_W-1:0] even_rgb_i,
  input  logic             even_de_i,
  input  logic             even_gp_i,
  input  logic             hs_i,
  input  logic             vs_i,
  output logic             valid_o,
  output logic [RGB_W-1:0] odd_rgb_o,
  output logic [RGB_W-1:0] even_rgb_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             de_o,
  output logic             odd_gp_o,
  output logic             even_gp_o
);
  logic             pad;
  logic [RGB_W-1:0] even_rgb_m;

  // line ended on the odd slot: close the pair with blank colour
  assign pad = odd_de_i & ~even_de_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign even_rgb_m[ch*CH_W +: CH_W] = pad ? '0 : even_rgb_i[ch*CH_W +: CH_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_rgb_o  <= '0;
      even_rgb_o <= '0;
      hs_o       <= 1'b0;
      vs_o       <= 1'b0;
      de_o       <= 1'b0;
      odd_gp_o   <= 1'b0;
      even_gp_o  <= 1'b0;
    end else if (emit_i) begin
      odd_rgb_o  <= odd_rgb_i;
      even_rgb_o <= even_rgb_m;
      hs_o       <= hs_i;
      vs_o       <= vs_i;
      de_o       <= odd_de_i;
      odd_gp_o   <= odd_gp_i;
      even_gp_o  <= even_gp_i;
    end
  end
endmodule

// File: rtl/pix_pair_packer.sv
module pix_pair_packer
  import pix_pair_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int NUM_CH = 3,
  localparam int RGB_W = CH_W * NUM_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RGB_W-1:0] rgb_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             de_i,
  input  logic             gp_i,
  output logic             valid_o,
  output logic [RGB_W-1:0] odd_rgb_o,
  output logic [RGB_W-1:0] even_rgb_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             de_o,
  output logic             odd_gp_o,
  output logic             even_gp_o
);
  slot_e            slot;
  logic [RGB_W-1:0] held_rgb;
  logic             held_de;
  logic             held_gp;

  pp_phase_trk u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .de_i   (de_i),
    .slot_o (slot)
  );

  pp_odd_hold #(.RGB_W(RGB_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (slot == SLOT_ODD),
    .rgb_i     (rgb_i),
    .de_i      (de_i),
    .gp_i      (gp_i),
    .odd_rgb_o (held_rgb),
    .odd_de_o  (held_de),
    .odd_gp_o  (held_gp)
  );

  pp_pair_out #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .emit_i     (slot == SLOT_EVEN),
    .odd_rgb_i  (held_rgb),
    .odd_de_i   (held_de),
    .odd_gp_i   (held_gp),
    .even_rgb_i (rgb_i),
    .even_de_i  (de_i),
    .even_gp_i  (gp_i),
    .hs_i       (hs_i),
    .vs_i       (vs_i),
    .valid_o    (valid_o),
    .odd_rgb_o  (odd_rgb_o),
    .even_rgb_o (even_rgb_o),
    .hs_o       (hs_o),
    .vs_o       (vs_o),
    .de_o       (de_o),
    .odd_gp_o   (odd_gp_o),
    .even_gp_o  (even_gp_o)
  );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int RGB_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RGB_W-1:0] rgb_i,
  input logic             hs_i,
  input logic             vs_i,
  input logic             de_i,
  input logic             gp_i,
  input logic             valid_o,
  input logic [RGB_W-1:0] odd_rgb_o,
  input logic [RGB_W-1:0] even_rgb_o,
  input logic             hs_o,
  input logic             vs_o,
  input logic             de_o,
  input logic             odd_gp_o,
  input logic             even_gp_o
);
  p_first_odd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_i) |=> !valid_o);

  p_pair_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !($past(de_i, 2) && !$past(de_i)) |->
      (odd_rgb_o == $past(rgb_i, 2)) && (even_rgb_o == $past(rgb_i)));

  p_no_back2back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_ctrl_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hs_o == $past(hs_i)) && (vs_o == $past(vs_i)) && (de_o == $past(de_i, 2)));

  p_spare_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (odd_gp_o == $past(gp_i, 2)) && (even_gp_o == $past(gp_i)));

  p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(de_i, 2) && !$past(de_i) |-> (even_rgb_o == '0) && de_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(odd_rgb_o) && $stable(even_rgb_o) && $stable(de_o));
endmodule

bind pix_pair_packer pp_checker #(.RGB_W(RGB_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rgb_i      (rgb_i),
  .hs_i       (hs_i),
  .vs_i       (vs_i),
  .de_i       (de_i),
  .gp_i       (gp_i),
  .valid_o    (valid_o),
  .odd_rgb_o  (odd_rgb_o),
  .even_rgb_o (even_rgb_o),
  .hs_o       (hs_o),
  .vs_o       (vs_o),
  .de_o       (de_o),
  .odd_gp_o   (odd_gp_o),
  .even_gp_o  (even_gp_o)
);

// File: tb/pix_pair_packer_bench.sv
module pix_pair_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RGB_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [RGB_W-1:0] rgb = '0;
  logic             hs = 1'b0, vs = 1'b0, de = 1'b0, gp = 1'b0;
  logic             valid;
  logic [RGB_W-1:0] odd_rgb, even_rgb;
  logic             hs_q, vs_q, de_q, odd_gp, even_gp;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_pair_packer u_pix_pair_packer (
    .clk_i(clk), .rst_ni(rst_n), .rgb_i(rgb), .hs_i(hs), .vs_i(vs), .de_i(de), .gp_i(gp),
    .valid_o(valid), .odd_rgb_o(odd_rgb), .even_rgb_o(even_rgb), .hs_o(hs_q), .vs_o(vs_q),
    .de_o(de_q), .odd_gp_o(odd_gp), .even_gp_o(even_gp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive on the falling edge, observe just after the sampling edge
  task automatic push(input logic [RGB_W-1:0] c, input logic h, input logic v,
                      input logic d, input logic g);
    @(negedge clk);
    rgb = c; hs = h; vs = v; de = d; gp = g;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid", valid, 0);
    chk("R1 odd_rgb", odd_rgb, 0);
    chk("R1 even_rgb", even_rgb, 0);
    chk("R1 ctrl", {hs_q, vs_q, de_q, odd_gp, even_gp}, 0);
  endtask

  task automatic t_even_line;
    push(24'h112233, 0, 0, 1, 1);
    chk("R2 first odd no strobe", valid, 0);
    push(24'h445566, 1, 0, 1, 0);
    chk("R3 valid", valid, 1);
    chk("R3 odd", odd_rgb, 24'h112233);
    chk("R3 even", even_rgb, 24'h445566);
    chk("R5 hs/de", {hs_q, de_q}, 2'b11);
    chk("R6 spare", {odd_gp, even_gp}, 2'b10);
    push(24'h778899, 0, 0, 1, 0);
    chk("R4 no back-to-back", valid, 0);
    chk("R9 hold odd", odd_rgb, 24'h112233);
    chk("R9 hold even", even_rgb, 24'h445566);
    push(24'hAABBCC, 0, 1, 1, 1);
    chk("R3 second pair", {valid, odd_rgb, even_rgb} == {1'b1, 24'h778899, 24'hAABBCC}, 1);
  endtask

  task automatic t_blank;
    push(24'h0F0F0F, 1, 0, 0, 0);
    chk("R4 blank odd", valid, 0);
    push(24'hF0F0F0, 0, 1, 0, 1);
    chk("R4 blank pair", valid, 1);
    chk("R5 blank ctrl from second", {hs_q, vs_q, de_q}, 3'b010);
    chk("R3 blank data", {odd_rgb, even_rgb} == {24'h0F0F0F, 24'hF0F0F0}, 1);
  endtask

  task automatic t_odd_line;
    push(24'h010203, 0, 0, 1, 1);
    chk("R2 odd line start", valid, 0);
    push(24'h040506, 0, 0, 1, 1);
    chk("R3 odd line pair", {valid, odd_rgb, even_rgb} == {1'b1, 24'h010203, 24'h040506}, 1);
    push(24'h070809, 0, 0, 1, 1);
    chk("R4 odd line tail", valid, 0);
    push(24'hDEAD55, 1, 0, 0, 0);
    chk("R7 pad valid", valid, 1);
    chk("R7 pad odd", odd_rgb, 24'h070809);
    chk("R7 pad even zero", even_rgb, 0);
    chk("R7 pad de", de_q, 1);
    chk("R6 pad spare", {odd_gp, even_gp}, 2'b10);
  endtask

  task automatic t_resync;
    push(24'h999999, 0, 0, 0, 1);
    chk("R8 pending blank odd", valid, 0);
    push(24'h123456, 0, 0, 1, 0);
    chk("R8 rise drops pending", valid, 0);
    chk("R9 hold after drop", even_rgb, 0);
    push(24'h654321, 0, 0, 1, 1);
    chk("R8 resync pair valid", valid, 1);
    chk("R8 resync odd", odd_rgb, 24'h123456);
    chk("R8 resync even", even_rgb, 24'h654321);
    chk("R6 resync spare", {odd_gp, even_gp}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_even_line();
    t_blank();
    t_odd_line();
    t_resync();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule